// File: doc/BRIEF.md
# MII Receive Frame Checker

This block sits behind the receive half of a 10/100 media independent interface. It watches the four-bit receive data lane together with its data-valid qualifier. It hunts for the end of the preamble, and once the start-of-frame delimiter has gone by it packs nibbles into bytes and forwards them as a byte stream. The stream carries a first-byte marker and a last-byte marker. While bytes arrive it runs a CRC-32 over everything after the delimiter, including the trailing frame check sequence.

When data-valid drops, the block emits one status strobe for the frame. The strobe gives the byte count, the group-address bit taken from the first destination byte, and three error flags: checksum mismatch, runt length, and a dangling half byte. It also gives a single good/bad verdict built from those flags. A downstream buffer manager uses the verdict to commit or drop what it has stored from the stream. Address filtering and frame storage belong to other blocks.

The stream runs one byte behind the wire. That lag lets the end marker sit on the true last byte, in the same cycle as the status strobe.

Top module: `mii_rx_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid`, `out_sof`, `out_eof`, `stat_valid` and `stat_good` are 0.
- R2: A frame starts only when, with `rx_dv` high, a nibble 0xD arrives in the cycle directly after a nibble 0x5. No other nibble sequence starts a frame, and preamble nibbles produce no output.
- R3: If `rx_dv` falls before a frame has started, the block keeps hunting and produces neither stream bytes nor a status strobe.
- R4: After the delimiter, each pair of nibbles sampled with `rx_dv` high forms one byte, with the first nibble of the pair in bits 3:0. All bytes, the four FCS bytes included, appear on `out_data` in arrival order. `out_sof` is set on the first byte only.
- R5: `out_eof` is set on the last byte of a frame only. That byte appears in the same cycle as the single `stat_valid` pulse for the frame, which comes at the clock edge that first samples `rx_dv` low.
- R6: `stat_len` equals the number of complete bytes received after the delimiter, FCS included.
- R7: The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is updated with every complete byte, least significant bit first. `stat_crc_err` is 0 exactly when the register equals 0xDEBB20E3 after the last byte (the bit-reversed form of residue 0xC704DD7B). A frame with no bytes is therefore a checksum error.
- R8: `stat_short` is 1 exactly when `stat_len` is below `MIN_LEN` (default 64).
- R9: `stat_odd` is 1 when a single unpaired nibble was received before `rx_dv` fell. That nibble is dropped from the stream and from the count.
- R10: `stat_mcast` equals bit 0 of the first byte after the delimiter, and is 0 when the frame has no bytes.
- R11: `stat_good` is 1 exactly when `stat_crc_err`, `stat_short` and `stat_odd` are all 0. It is pulsed only together with `stat_valid`.
- R12: Nibbles presented while `rx_dv` is low have no effect: no output, no frame start, no CRC update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rxd | input | 4 | Receive nibble from the PHY |
| out_valid | output | 1 | A stream byte is present this cycle |
| out_data | output | 8 | Stream byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| stat_valid | output | 1 | One-cycle end-of-frame status strobe |
| stat_good | output | 1 | Frame passes every check |
| stat_mcast | output | 1 | Group-address bit of the first byte |
| stat_len | output | LEN_W | Complete bytes received after the delimiter |
| stat_crc_err | output | 1 | CRC residue mismatch |
| stat_short | output | 1 | Frame shorter than MIN_LEN bytes |
| stat_odd | output | 1 | Unpaired trailing nibble seen |

## Verification
Frames are swept across lengths on both sides of the 64-byte limit, each with a correct FCS and with a corrupted payload byte. This separates the length check from the residue check. Very short frames, from zero bytes up, are sent with and without a trailing half nibble, which tests byte counting, the odd flag and the multicast bit at their edges. Preamble lengths down to a single 0x5 nibble show that the delimiter is found wherever it falls. Three further cases must all stay silent: a preamble cut off before the delimiter, 0xD nibbles not directly preceded by 0x5, and nibble activity with data-valid low.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    localparam logic [3:0]  NIB_PRE     = 4'h5;
    localparam logic [3:0]  NIB_SFD     = 4'hD;
    localparam logic [31:0] CRC_POLY_RF = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_BODY = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
    } beat_t;

    typedef struct packed {
        logic crc_err;
        logic short_f;
        logic odd;
    } frame_err_t;

    // One byte through the reflected CRC-32, LSB first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_RF) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mrx_delim.sv
module mrx_delim
    import mrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_dv,
    input  logic [3:0] rxd,
    output logic       frame_start,
    output logic       frame_end,
    output logic       body_en
);

    rx_state_e st_q;
    logic      prev_pre_q;

    always_comb begin
        frame_start = (st_q == ST_HUNT) && rx_dv && (rxd == NIB_SFD) && prev_pre_q;
        frame_end   = (st_q == ST_BODY) && !rx_dv;
        body_en     = (st_q == ST_BODY) && rx_dv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HUNT;
            prev_pre_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    prev_pre_q <= rx_dv && (rxd == NIB_PRE);
                    if (frame_start) st_q <= ST_BODY;
                end
                ST_BODY: begin
                    prev_pre_q <= 1'b0;
                    if (!rx_dv) st_q <= ST_HUNT;
                end
                default: st_q <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/mrx_nibble_pack.sv
module mrx_nibble_pack (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       nib_en,
    input  logic [3:0] rxd,
    output logic       byte_stb,
    output logic [7:0] byte_data,
    output logic       half_pending
);

    logic       phase_q;
    logic [3:0] lo_q;

    always_comb begin
        byte_stb     = nib_en && phase_q;
        byte_data    = {rxd, lo_q};
        half_pending = phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= 1'b0;
            lo_q    <= 4'h0;
        end else if (nib_en) begin
            phase_q <= ~phase_q;
            if (!phase_q) lo_q <= rxd;
        end
    end

endmodule

// File: rtl/mrx_crc32.sv
module mrx_crc32
    import mrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= CRC_SEED;
        end else if (upd) begin
            crc_q <= crc32_byte(crc_q, data);
        end
    end

endmodule

// File: rtl/mii_rx_checker.sv
module mii_rx_checker
    import mrx_pkg::*;
#(
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_dv,
    input  logic [3:0]       rxd,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             stat_valid,
    output logic             stat_good,
    output logic             stat_mcast,
    output logic [LEN_W-1:0] stat_len,
    output logic             stat_crc_err,
    output logic             stat_short,
    output logic             stat_odd
);

    localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    logic        frame_start, frame_end, body_en;
    logic        byte_stb, half_pending;
    logic [7:0]  byte_data;
    logic [31:0] crc_q;

    beat_t            hold_q;
    logic             hold_v_q;
    logic             first_q;
    logic             mcast_q;
    logic [LEN_W-1:0] cnt_q;
    frame_err_t       ferr;

    mrx_delim u_delim (
        .clk         (clk),
        .rst         (rst),
        .rx_dv       (rx_dv),
        .rxd         (rxd),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .body_en     (body_en)
    );

    mrx_nibble_pack u_pack (
        .clk          (clk),
        .rst          (rst),
        .clear        (frame_start),
        .nib_en       (body_en),
        .rxd          (rxd),
        .byte_stb     (byte_stb),
        .byte_data    (byte_data),
        .half_pending (half_pending)
    );

    mrx_crc32 u_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (frame_start),
        .upd   (byte_stb),
        .data  (byte_data),
        .crc_q (crc_q)
    );

    always_comb begin
        ferr.crc_err = (crc_q != CRC_RESIDUE);
        ferr.short_f = (cnt_q < MIN_L);
        ferr.odd     = half_pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q       <= '0;
            hold_v_q     <= 1'b0;
            first_q      <= 1'b0;
            mcast_q      <= 1'b0;
            cnt_q        <= '0;
            out_valid    <= 1'b0;
            out_data     <= 8'h00;
            out_sof      <= 1'b0;
            out_eof      <= 1'b0;
            stat_valid   <= 1'b0;
            stat_good    <= 1'b0;
            stat_mcast   <= 1'b0;
            stat_len     <= '0;
            stat_crc_err <= 1'b0;
            stat_short   <= 1'b0;
            stat_odd     <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            stat_valid <= 1'b0;
            stat_good  <= 1'b0;
            if (frame_start) begin
                hold_v_q <= 1'b0;
                first_q  <= 1'b1;
                mcast_q  <= 1'b0;
                cnt_q    <= '0;
            end else if (byte_stb) begin
                if (hold_v_q) begin
                    out_valid <= 1'b1;
                    out_data  <= hold_q.data;
                    out_sof   <= hold_q.sof;
                end
                hold_q.data <= byte_data;
                hold_q.sof  <= first_q;
                hold_v_q    <= 1'b1;
                first_q     <= 1'b0;
                if (first_q) mcast_q <= byte_data[0];
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end else if (frame_end) begin
                if (hold_v_q) begin
                    out_valid <= 1'b1;
                    out_data  <= hold_q.data;
                    out_sof   <= hold_q.sof;
                    out_eof   <= 1'b1;
                end
                hold_v_q     <= 1'b0;
                stat_valid   <= 1'b1;
                stat_len     <= cnt_q;
                stat_mcast   <= mcast_q;
                stat_crc_err <= ferr.crc_err;
                stat_short   <= ferr.short_f;
                stat_odd     <= ferr.odd;
                stat_good    <= ~(ferr.crc_err | ferr.short_f | ferr.odd);
            end
        end
    end

endmodule

// File: rtl/mii_rx_checker_chk.sv
module mii_rx_checker_chk #(
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_dv,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic             stat_valid,
    input logic             stat_good,
    input logic             stat_mcast,
    input logic [LEN_W-1:0] stat_len,
    input logic             stat_crc_err,
    input logic             stat_short
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

    p_eof_with_status_r5: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (stat_valid && out_valid));

    p_status_has_eof_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_len != '0) |-> out_eof);

    p_sof_is_byte_r4: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    p_mid_byte_needs_dv_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eof) |-> $past(rx_dv));

    p_runt_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_len < MIN_L) |-> (stat_short && !stat_good));

    p_long_no_runt_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_len >= MIN_L) |-> !stat_short);

    p_empty_crc_bad_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_len == '0) |-> stat_crc_err);

    p_empty_no_mcast_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_len == '0) |-> !stat_mcast);

    p_good_is_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        stat_good |-> stat_valid);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rx_dv) && !$past(rx_dv, 2)) |-> (!out_valid && !stat_valid));

endmodule

bind mii_rx_checker mii_rx_checker_chk #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_dv        (rx_dv),
    .out_valid    (out_valid),
    .out_sof      (out_sof),
    .out_eof      (out_eof),
    .stat_valid   (stat_valid),
    .stat_good    (stat_good),
    .stat_mcast   (stat_mcast),
    .stat_len     (stat_len),
    .stat_crc_err (stat_crc_err),
    .stat_short   (stat_short)
);

// File: tb/mii_rx_checker_tb.sv
module mii_rx_checker_tb;

    localparam int MIN_LEN = 64;
    localparam int LEN_W   = 16;
    localparam logic [31:0] GOOD_RES = 32'hDEBB20E3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_dv = 1'b0;
    logic [3:0]       rxd = 4'h0;
    logic             out_valid, out_sof, out_eof;
    logic [7:0]       out_data;
    logic             stat_valid, stat_good, stat_mcast, stat_crc_err, stat_short, stat_odd;
    logic [LEN_W-1:0] stat_len;

    mii_rx_checker #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .rx_dv(rx_dv), .rxd(rxd),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .stat_valid(stat_valid), .stat_good(stat_good), .stat_mcast(stat_mcast),
        .stat_len(stat_len), .stat_crc_err(stat_crc_err), .stat_short(stat_short),
        .stat_odd(stat_odd)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] fb    [0:255];
    logic [7:0] cap_d [0:255];
    logic       cap_s [0:255];
    logic       cap_e [0:255];
    int   cap_n = 0;
    int   st_n  = 0;
    int   st_len = 0;
    logic st_good, st_mcast, st_crc, st_short, st_odd, st_eof;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (cap_n < 256) begin
                    cap_d[cap_n] = out_data;
                    cap_s[cap_n] = out_sof;
                    cap_e[cap_n] = out_eof;
                end
                cap_n++;
            end
            if (stat_valid) begin
                st_n++;
                st_len   = int'(stat_len);
                st_good  = stat_good;
                st_mcast = stat_mcast;
                st_crc   = stat_crc_err;
                st_short = stat_short;
                st_odd   = stat_odd;
                st_eof   = out_eof;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, fb[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    task automatic nib(input logic dv, input logic [3:0] v);
        rx_dv = dv;
        rxd   = v;
        @(posedge clk);
        #1;
    endtask

    task automatic build(input int nb, input int seed, input bit mc, input bit fcs_ok);
        logic [31:0] c;
        for (int i = 0; i < nb; i++) fb[i] = 8'((i * 37 + seed * 11 + 3) % 256);
        if (nb > 0) fb[0][0] = mc;
        if (nb >= 4) begin
            c = ~ref_crc(nb - 4);
            for (int k = 0; k < 4; k++) fb[nb - 4 + k] = c[8*k +: 8];
        end
        if (!fcs_ok && nb >= 5) fb[1] = fb[1] ^ 8'h10;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nib(1'b0, (i % 2 == 0) ? 4'h5 : 4'hD);
    endtask

    task automatic send(input int nb, input bit odd_tail, input int pre_n);
        int bad;
        bit exp_crc, exp_short;
        cap_n = 0;
        st_n  = 0;
        for (int i = 0; i < pre_n; i++) nib(1'b1, 4'h5);
        nib(1'b1, 4'hD);
        for (int i = 0; i < nb; i++) begin
            nib(1'b1, fb[i][3:0]);
            nib(1'b1, fb[i][7:4]);
        end
        if (odd_tail) nib(1'b1, 4'h9);
        idle(4);
        bad = 0;
        for (int i = 0; i < nb && i < 256; i++) begin
            if (cap_d[i] !== fb[i] || cap_s[i] !== (i == 0) || cap_e[i] !== (i == nb - 1)) bad++;
        end
        exp_crc   = (ref_crc(nb) != GOOD_RES);
        exp_short = (nb < MIN_LEN);
        chk("R4 stream byte count", cap_n, nb);
        chk("R4 byte order and sof/eof marks", bad, 0);
        chk("R5 single status strobe", st_n, 1);
        chk("R5 eof with status", int'(st_eof), int'(nb > 0));
        chk("R6 length", st_len, nb);
        chk("R7 crc error flag", int'(st_crc), int'(exp_crc));
        chk("R8 short flag", int'(st_short), int'(exp_short));
        chk("R9 odd flag", int'(st_odd), int'(odd_tail));
        chk("R10 multicast bit", int'(st_mcast), (nb > 0) ? int'(fb[0][0]) : 0);
        chk("R11 good verdict", int'(st_good), int'(!exp_crc && !exp_short && !odd_tail));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 stat_valid in reset", int'(stat_valid), 0);
        chk("R1 markers in reset", int'(out_sof | out_eof | stat_good), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", int'(out_valid | stat_valid | out_sof | out_eof | stat_good), 0);
        @(posedge clk);
        #1;

        // R6 R7 R8 R11: lengths around the runt limit, good and corrupted FCS
        for (int nb = 60; nb <= 72; nb++) begin
            build(nb, nb, nb[0], 1'b1);
            send(nb, 1'b0, 15);
            build(nb, nb + 3, ~nb[0], 1'b0);
            send(nb, 1'b0, 15);
        end

        // R9 R10: tiny and boundary frames with and without a dangling nibble
        foreach (fb[j]) fb[j] = 8'h00;
        for (int s = 0; s < 11; s++) begin
            int sizes [11] = '{0, 1, 2, 3, 4, 5, 8, 20, 63, 64, 65};
            for (int od = 0; od < 2; od++) begin
                build(sizes[s], s * 7 + od, 1'((s + od) % 2), 1'b1);
                send(sizes[s], 1'(od), 7);
            end
        end

        // R2: every preamble length down to a single 0x5 nibble
        for (int p = 1; p <= 15; p++) begin
            build(64 + p, p, 1'(p % 2), 1'b1);
            send(64 + p, 1'b0, p);
        end

        // R3: preamble cut off before the delimiter
        cap_n = 0; st_n = 0;
        for (int i = 0; i < 14; i++) nib(1'b1, 4'h5);
        idle(6);
        chk("R3 no output after aborted preamble", cap_n + st_n, 0);

        // R2: 0xD not directly preceded by 0x5
        cap_n = 0; st_n = 0;
        nib(1'b1, 4'hD); nib(1'b1, 4'hD); nib(1'b1, 4'h3); nib(1'b1, 4'h5);
        nib(1'b1, 4'hA); nib(1'b1, 4'hD); nib(1'b1, 4'h7); nib(1'b1, 4'hD);
        idle(6);
        chk("R2 no frame without 5 then D", cap_n + st_n, 0);

        // R12: activity with data-valid low, then a normal frame
        cap_n = 0; st_n = 0;
        idle(24);
        chk("R12 no output while rx_dv low", cap_n + st_n, 0);
        build(66, 9, 1'b1, 1'b1);
        send(66, 1'b0, 15);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule